// File: doc/BRIEF.md
# Data Cache Mode and Access Router

This block sits between a load/store unit and a small data cache with its bus interface. For every access it accepts, it decides whether the cache answers, whether a cache line is fetched with a burst, or whether the access goes to the bus as a single cache-inhibited beat. It also decides whether a cache-management operation must send an address-only broadcast. Three configuration inputs drive these decisions: cache enable, whole-cache lock and broadcast enable. The block copies them into shadow registers only while no access is in progress. The line state (tag, valid, dirty) lives in a small store inside the block.

The block accepts one access at a time through a valid/ready handshake. It reports the outcome as a one-cycle response pulse with hit, inhibited, broadcast and write-back flags. A snoop port invalidates matching lines, but only while the cache is enabled. Cache-management operations always act on the line state, whatever the enable setting.

Top module: `dc_route`

## Requirements
- R1: After reset, enable, lock and broadcast-enable are all off. `req_ready` is 1, and `bus_req`, `rsp_valid` and `snp_hit` are 0.
- R2: With the cache disabled, a load (op 0) or a store (op 1) ignores the line state. It issues a single-beat bus transfer with `bus_ci`=1 (`bus_we`=1 for a store) and responds with `rsp_ci`=1 and `rsp_hit`=0.
- R3: With the cache disabled, a snoop gives `snp_hit`=0 and leaves the line state unchanged.
- R4: Management operations act on the line state even when the cache is disabled. A flush of a dirty line then still reports `rsp_wb`=1.
- R5: With the lock set, a load or store that hits is answered from the cache. A miss becomes a single-beat inhibited transfer (`rsp_ci`=1) that allocates nothing.
- R6: The configuration inputs are sampled only while idle. The value present at the accepting edge governs that access, and changes made while an access is in flight leave it unaffected.
- R7: Op codes are 0 load, 1 store, 2 zero-line, 3 flush, 4 clean and 5 invalidate. A zero-line operation always issues one address-only bus beat (`bus_aonly`=1) and responds with `rsp_bcast`=1.
- R8: Flush, clean and invalidate issue an address-only beat, with `rsp_bcast`=1, only when `cfg_bcast` is set. Otherwise they complete without any bus request.
- R9: A load or store with `req_inh`=1 is handled as inhibited, single beat with `rsp_ci`=1, even when its line is present.
- R10: The line index is `req_addr[6:4]` and the tag is `req_addr[15:7]`. A load or store miss with the cache enabled and unlocked issues a 4-beat burst (`bus_burst`=1, `bus_ci`=0). Afterwards the line is valid: clean for a load, dirty for a store.
- R11: A store hit marks the line dirty. Flush or clean of a dirty line gives `rsp_wb`=1. Flush and invalidate remove the line, while clean keeps it valid and clean.
- R12: Only one access is in flight. `req_ready` stays 0 from acceptance until the cycle after the final `bus_ack`, and that cycle also carries the one-cycle `rsp_valid`. A no-bus access responds two cycles after acceptance.
- R13: With the cache enabled, a snoop that matches a valid line gives `snp_hit`=1 one cycle later and invalidates that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Cache enable request |
| cfg_lock | input | 1 | Whole-cache lock request |
| cfg_bcast | input | 1 | Broadcast enable for flush/clean/invalidate |
| req_valid | input | 1 | Access request valid |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Byte address |
| req_inh | input | 1 | Per-access inhibit attribute |
| req_ready | output | 1 | Block can accept an access |
| snp_valid | input | 1 | Snoop request |
| snp_line | input | AW-4 | Snoop line address |
| snp_hit | output | 1 | Snoop matched and invalidated a line |
| bus_req | output | 1 | Bus transaction pending |
| bus_burst | output | 1 | Transaction is a line burst |
| bus_ci | output | 1 | Transaction is cache-inhibited |
| bus_aonly | output | 1 | Transaction is address-only |
| bus_we | output | 1 | Transaction writes |
| bus_addr | output | AW | Transaction address |
| bus_ack | input | 1 | One beat completed |
| rsp_valid | output | 1 | Access completed (one cycle) |
| rsp_hit | output | 1 | Line was present |
| rsp_ci | output | 1 | Access was serviced as inhibited |
| rsp_bcast | output | 1 | Address-only broadcast was issued |
| rsp_wb | output | 1 | Dirty line needs write-back |

## Verification
The same two addresses are revisited under every combination of enable, lock, inhibit and broadcast setting. A line that is known to be valid, dirty or absent then separates a real hit from a tag check that is wrongly skipped or wrongly applied. Loads after each flush, clean, invalidate and snoop show the resulting line state through hit or burst behaviour. Bus acknowledges arrive with idle gaps between them, which separates a correct beat count and stall from an early release. One access flips the enable input in the middle of its burst, to show that configuration is sampled only when the block is idle.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ZERO  = 3'd2,
    OP_FLUSH = 3'd3,
    OP_CLEAN = 3'd4,
    OP_INVAL = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_BUS
  } st_e;

  typedef struct packed {
    logic use_bus;
    logic burst;
    logic ci;
    logic aonly;
    logic we;
    logic hit;
    logic wb;
    logic upd;
    logic nv;
    logic nd;
  } dec_t;

endpackage

// File: rtl/dcr_tags.sv
module dcr_tags #(
  parameter int LINES = 8,
  parameter int IDXW  = 3,
  parameter int TAGW  = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TAGW+IDXW-1:0] lk_line,
  output logic                 lk_hit,
  output logic                 lk_dirty,
  input  logic                 wr_en,
  input  logic                 wr_valid,
  input  logic                 wr_dirty,
  input  logic                 sn_valid,
  input  logic                 sn_enable,
  input  logic [TAGW+IDXW-1:0] sn_line,
  output logic                 sn_hit
);

  logic [LINES-1:0] vld;
  logic [LINES-1:0] drt;
  logic [TAGW-1:0]  tagm [LINES];

  logic [IDXW-1:0] lk_idx;
  logic [TAGW-1:0] lk_tag;
  logic [IDXW-1:0] sn_idx;
  logic [TAGW-1:0] sn_tag;
  logic            sn_match;

  assign lk_idx   = lk_line[IDXW-1:0];
  assign lk_tag   = lk_line[TAGW+IDXW-1:IDXW];
  assign sn_idx   = sn_line[IDXW-1:0];
  assign sn_tag   = sn_line[TAGW+IDXW-1:IDXW];

  assign lk_hit   = vld[lk_idx] && (tagm[lk_idx] == lk_tag);
  assign lk_dirty = drt[lk_idx];
  assign sn_match = vld[sn_idx] && (tagm[sn_idx] == sn_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      drt    <= '0;
      sn_hit <= 1'b0;
    end else begin
      sn_hit <= sn_valid && sn_enable && sn_match;
      if (sn_valid && sn_enable && sn_match) begin
        vld[sn_idx] <= 1'b0;
        drt[sn_idx] <= 1'b0;
      end
      if (wr_en) begin
        vld[lk_idx] <= wr_valid;
        drt[lk_idx] <= wr_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tagm[lk_idx] <= lk_tag;
  end

endmodule

// File: rtl/dcr_decide.sv
module dcr_decide
  import dcr_pkg::*;
(
  input  logic [2:0] op,
  input  logic       inh,
  input  logic       en,
  input  logic       lock,
  input  logic       bcast,
  input  logic       hit,
  input  logic       dirty,
  output dec_t       dec
);

  always_comb begin
    dec    = '0;
    dec.we = (op == OP_STORE);
    case (op)
      OP_LOAD, OP_STORE: begin
        if (!en || inh || (lock && !hit)) begin
          dec.use_bus = 1'b1;
          dec.ci      = 1'b1;
        end else if (hit) begin
          dec.hit = 1'b1;
          if (op == OP_STORE) begin
            dec.upd = 1'b1;
            dec.nv  = 1'b1;
            dec.nd  = 1'b1;
          end
        end else begin
          dec.use_bus = 1'b1;
          dec.burst   = 1'b1;
          dec.upd     = 1'b1;
          dec.nv      = 1'b1;
          dec.nd      = (op == OP_STORE);
        end
      end
      OP_ZERO, OP_FLUSH, OP_CLEAN, OP_INVAL: begin
        dec.hit     = hit;
        dec.aonly   = (op == OP_ZERO) || bcast;
        dec.use_bus = dec.aonly;
        dec.wb      = hit && dirty && ((op == OP_FLUSH) || (op == OP_CLEAN));
        if (hit) begin
          dec.upd = 1'b1;
          dec.nv  = (op == OP_ZERO) || (op == OP_CLEAN);
          dec.nd  = (op == OP_ZERO);
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
  import dcr_pkg::*;
#(
  parameter int AW    = 16,
  parameter int OFFW  = 4,
  parameter int BEATS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_en,
  input  logic            cfg_lock,
  input  logic            cfg_bcast,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_inh,
  output logic            req_ready,
  output logic [2:0]      q_op,
  output logic            q_inh,
  output logic [AW-OFFW-1:0] q_line,
  output logic            act_en,
  output logic            act_lock,
  output logic            act_bcast,
  input  dec_t            dec,
  output logic            wr_en,
  output logic            wr_valid,
  output logic            wr_dirty,
  input  logic            bus_ack,
  output logic            bus_req,
  output logic            bus_burst,
  output logic            bus_ci,
  output logic            bus_aonly,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_ci,
  output logic            rsp_bcast,
  output logic            rsp_wb
);

  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

  st_e          st;
  logic [AW-1:0] q_addr;
  logic [BW-1:0] beat;
  logic k_hit, k_ci, k_ao, k_wb, k_upd, k_nv, k_nd;
  logic look_done, bus_done;

  assign req_ready = (st == ST_IDLE);
  assign q_line    = q_addr[AW-1:OFFW];
  assign look_done = (st == ST_LOOK) && !dec.use_bus;
  assign bus_done  = (st == ST_BUS) && bus_ack && (beat == '0);

  assign wr_en    = (look_done && dec.upd) || (bus_done && k_upd);
  assign wr_valid = look_done ? dec.nv : k_nv;
  assign wr_dirty = look_done ? dec.nd : k_nd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      q_op      <= '0;
      q_inh     <= 1'b0;
      q_addr    <= '0;
      act_en    <= 1'b0;
      act_lock  <= 1'b0;
      act_bcast <= 1'b0;
      beat      <= '0;
      {k_hit, k_ci, k_ao, k_wb, k_upd, k_nv, k_nd} <= '0;
      {bus_req, bus_burst, bus_ci, bus_aonly, bus_we} <= '0;
      bus_addr  <= '0;
      {rsp_valid, rsp_hit, rsp_ci, rsp_bcast, rsp_wb} <= '0;
    end else begin
      {rsp_valid, rsp_hit, rsp_ci, rsp_bcast, rsp_wb} <= '0;
      case (st)
        ST_IDLE: begin
          act_en    <= cfg_en;
          act_lock  <= cfg_lock;
          act_bcast <= cfg_bcast;
          if (req_valid) begin
            q_op   <= req_op;
            q_inh  <= req_inh;
            q_addr <= req_addr;
            st     <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          k_hit <= dec.hit;
          k_ci  <= dec.ci;
          k_ao  <= dec.aonly;
          k_wb  <= dec.wb;
          k_upd <= dec.upd;
          k_nv  <= dec.nv;
          k_nd  <= dec.nd;
          if (dec.use_bus) begin
            bus_req   <= 1'b1;
            bus_burst <= dec.burst;
            bus_ci    <= dec.ci;
            bus_aonly <= dec.aonly;
            bus_we    <= dec.we;
            bus_addr  <= q_addr;
            beat      <= dec.burst ? BW'(BEATS - 1) : '0;
            st        <= ST_BUS;
          end else begin
            rsp_valid <= 1'b1;
            rsp_hit   <= dec.hit;
            rsp_ci    <= dec.ci;
            rsp_bcast <= dec.aonly;
            rsp_wb    <= dec.wb;
            st        <= ST_IDLE;
          end
        end
        ST_BUS: begin
          if (bus_ack) begin
            if (beat == '0) begin
              {bus_req, bus_burst, bus_ci, bus_aonly, bus_we} <= '0;
              rsp_valid <= 1'b1;
              rsp_hit   <= k_hit;
              rsp_ci    <= k_ci;
              rsp_bcast <= k_ao;
              rsp_wb    <= k_wb;
              st        <= ST_IDLE;
            end else begin
              beat <= beat - 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dc_route.sv
module dc_route
  import dcr_pkg::*;
#(
  parameter int AW         = 16,
  parameter int LINE_BYTES = 16,
  parameter int LINES      = 8,
  parameter int BEATS      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_en,
  input  logic               cfg_lock,
  input  logic               cfg_bcast,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [AW-1:0]      req_addr,
  input  logic               req_inh,
  output logic               req_ready,
  input  logic               snp_valid,
  input  logic [AW-$clog2(LINE_BYTES)-1:0] snp_line,
  output logic               snp_hit,
  output logic               bus_req,
  output logic               bus_burst,
  output logic               bus_ci,
  output logic               bus_aonly,
  output logic               bus_we,
  output logic [AW-1:0]      bus_addr,
  input  logic               bus_ack,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_ci,
  output logic               rsp_bcast,
  output logic               rsp_wb
);

  localparam int OFFW = $clog2(LINE_BYTES);
  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - OFFW - IDXW;

  logic [2:0]         q_op;
  logic               q_inh;
  logic [AW-OFFW-1:0] q_line;
  logic               act_en, act_lock, act_bcast;
  logic               lk_hit, lk_dirty;
  logic               wr_en, wr_valid, wr_dirty;
  dec_t               dec;

  dcr_tags #(.LINES(LINES), .IDXW(IDXW), .TAGW(TAGW)) u_tags (
    .clk(clk), .rst(rst),
    .lk_line(q_line), .lk_hit(lk_hit), .lk_dirty(lk_dirty),
    .wr_en(wr_en), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
    .sn_valid(snp_valid), .sn_enable(act_en), .sn_line(snp_line),
    .sn_hit(snp_hit)
  );

  dcr_decide u_decide (
    .op(q_op), .inh(q_inh), .en(act_en), .lock(act_lock), .bcast(act_bcast),
    .hit(lk_hit), .dirty(lk_dirty), .dec(dec)
  );

  dcr_ctrl #(.AW(AW), .OFFW(OFFW), .BEATS(BEATS)) u_ctrl (
    .clk(clk), .rst(rst),
    .cfg_en(cfg_en), .cfg_lock(cfg_lock), .cfg_bcast(cfg_bcast),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_inh(req_inh), .req_ready(req_ready),
    .q_op(q_op), .q_inh(q_inh), .q_line(q_line),
    .act_en(act_en), .act_lock(act_lock), .act_bcast(act_bcast),
    .dec(dec),
    .wr_en(wr_en), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
    .bus_ack(bus_ack), .bus_req(bus_req), .bus_burst(bus_burst),
    .bus_ci(bus_ci), .bus_aonly(bus_aonly), .bus_we(bus_we),
    .bus_addr(bus_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ci(rsp_ci),
    .rsp_bcast(rsp_bcast), .rsp_wb(rsp_wb)
  );

endmodule

// File: rtl/dcr_chk.sv
module dcr_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic bus_req,
  input logic bus_ack,
  input logic bus_burst,
  input logic bus_ci,
  input logic bus_aonly,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_ci,
  input logic rsp_bcast,
  input logic snp_hit,
  input logic act_en
);

  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req);

  // R12
  single_out_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !req_ready);

  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R12
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready && !bus_req);

  // R10
  burst_cacheable_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_burst |-> !bus_ci && !bus_aonly);

  // R7
  bcast_not_ci_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_bcast |-> !rsp_ci);

  // R5
  hit_not_ci_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_hit |-> !rsp_ci);

  // R3
  snoop_gate_chk: assert property (@(posedge clk) disable iff (rst)
    snp_hit |-> $past(act_en));

endmodule

bind dc_route dcr_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready),
  .bus_req(bus_req), .bus_ack(bus_ack), .bus_burst(bus_burst),
  .bus_ci(bus_ci), .bus_aonly(bus_aonly),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ci(rsp_ci),
  .rsp_bcast(rsp_bcast), .snp_hit(snp_hit), .act_en(act_en)
);

// File: tb/dc_route_bench.sv
module dc_route_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 0, cfg_lock = 0, cfg_bcast = 0;
  logic        req_valid = 0, req_inh = 0;
  logic [2:0]  req_op = 0;
  logic [15:0] req_addr = 0;
  logic        req_ready;
  logic        snp_valid = 0;
  logic [11:0] snp_line = 0;
  logic        snp_hit;
  logic        bus_req, bus_burst, bus_ci, bus_aonly, bus_we;
  logic [15:0] bus_addr;
  logic        bus_ack = 0;
  logic        rsp_valid, rsp_hit, rsp_ci, rsp_bcast, rsp_wb;

  int checks = 0;
  int errors = 0;

  bit mv[8];
  bit md[8];
  int mt[8];

  always #10 clk = ~clk;

  dc_route u_dc_route (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_lock(cfg_lock),
    .cfg_bcast(cfg_bcast), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_inh(req_inh), .req_ready(req_ready),
    .snp_valid(snp_valid), .snp_line(snp_line), .snp_hit(snp_hit),
    .bus_req(bus_req), .bus_burst(bus_burst), .bus_ci(bus_ci),
    .bus_aonly(bus_aonly), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_ack(bus_ack), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_ci(rsp_ci), .rsp_bcast(rsp_bcast), .rsp_wb(rsp_wb)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string rq, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic access(input int op, input logic [15:0] a, input bit inh,
                        input bit flip, input string rq);
    int idx, tg, nb;
    bit hit, drt, bus, burst, ci, ao, eh, wb, upd, nv, nd;
    @(negedge clk);
    chk(req_ready, 1, rq, "ready before accept");
    req_valid = 1; req_op = op[2:0]; req_addr = a; req_inh = inh;
    idx = int'(a[6:4]); tg = int'(a[15:7]);
    hit = mv[idx] && (mt[idx] == tg);
    drt = md[idx];
    {bus, burst, ci, ao, eh, wb, upd, nv, nd} = '0;
    if (op < 2) begin
      if (!cfg_en || inh || (cfg_lock && !hit)) begin bus = 1; ci = 1; end
      else if (hit) begin
        eh = 1;
        if (op == 1) begin upd = 1; nv = 1; nd = 1; end
      end else begin
        bus = 1; burst = 1; upd = 1; nv = 1; nd = (op == 1);
      end
    end else begin
      eh = hit;
      ao = (op == 2) || cfg_bcast;
      bus = ao;
      if (op == 3 || op == 4) wb = hit && drt;
      if (hit) begin upd = 1; nv = (op == 2 || op == 4); nd = (op == 2); end
    end
    nb = burst ? 4 : 1;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready, 0, rq, "ready low after accept");
    @(negedge clk);
    if (bus) begin
      chk(bus_req, 1, rq, "bus_req");
      chk(bus_burst, burst, rq, "bus_burst");
      chk(bus_ci, ci, rq, "bus_ci");
      chk(bus_aonly, ao, rq, "bus_aonly");
      chk(bus_we, (op == 1), rq, "bus_we");
      chk(bus_addr, a, rq, "bus_addr");
      chk(rsp_valid, 0, rq, "no early response");
      if (flip) cfg_en = !cfg_en;
      for (int b = 0; b < nb; b++) begin
        @(negedge clk);
        chk(bus_req, 1, rq, "bus_req held while waiting");
        chk(req_ready, 0, rq, "ready low while waiting");
        bus_ack = 1;
        @(negedge clk);
        bus_ack = 0;
        if (b < nb - 1) begin
          chk(bus_req, 1, rq, "bus_req mid burst");
          chk(rsp_valid, 0, rq, "no response mid burst");
        end
      end
    end
    chk(rsp_valid, 1, rq, "rsp_valid");
    chk(bus_req, 0, rq, "bus_req released");
    chk(req_ready, 1, rq, "ready at response");
    chk(rsp_hit, eh, rq, "rsp_hit");
    chk(rsp_ci, ci, rq, "rsp_ci");
    chk(rsp_bcast, ao, rq, "rsp_bcast");
    chk(rsp_wb, wb, rq, "rsp_wb");
    if (upd) begin mv[idx] = nv; md[idx] = nd; mt[idx] = tg; end
  endtask

  task automatic snoop(input logic [15:0] a, input string rq);
    int idx, tg;
    bit exp;
    @(negedge clk);
    idx = int'(a[6:4]); tg = int'(a[15:7]);
    exp = cfg_en && mv[idx] && (mt[idx] == tg);
    snp_valid = 1; snp_line = a[15:4];
    @(negedge clk);
    snp_valid = 0;
    chk(snp_hit, exp, rq, "snp_hit");
    if (exp) begin mv[idx] = 0; md[idx] = 0; end
  endtask

  localparam logic [15:0] A = 16'h1230;
  localparam logic [15:0] B = 16'h5630;
  localparam logic [15:0] C = 16'h0040;

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(req_ready, 1, "R1", "ready after reset");
    chk(bus_req, 0, "R1", "bus_req after reset");
    chk(rsp_valid, 0, "R1", "rsp_valid after reset");
    chk(snp_hit, 0, "R1", "snp_hit after reset");
    access(0, A, 0, 0, "R1");
    access(1, A, 0, 0, "R2");
    access(2, A, 0, 0, "R7");
    @(negedge clk) cfg_en = 1;
    access(0, A, 0, 0, "R10");
    access(0, A, 0, 0, "R10");
    access(1, A, 0, 0, "R11");
    @(negedge clk) cfg_en = 0;
    access(0, A, 0, 0, "R2");
    access(3, A, 0, 0, "R4");
    @(negedge clk) cfg_en = 1;
    access(0, A, 0, 0, "R11");
    @(negedge clk) cfg_bcast = 1;
    access(4, A, 0, 0, "R8");
    access(1, A, 0, 0, "R11");
    access(4, A, 0, 0, "R11");
    access(0, A, 0, 0, "R11");
    access(5, A, 0, 0, "R8");
    access(0, A, 0, 0, "R11");
    @(negedge clk) cfg_bcast = 0;
    access(3, A, 0, 0, "R8");
    access(0, A, 0, 0, "R10");
    access(0, A, 1, 0, "R9");
    access(1, A, 1, 0, "R9");
    @(negedge clk) cfg_lock = 1;
    access(0, A, 0, 0, "R5");
    access(0, B, 0, 0, "R5");
    access(1, B, 0, 0, "R5");
    access(0, A, 0, 0, "R5");
    @(negedge clk) cfg_lock = 0;
    snoop(A, "R13");
    access(0, A, 0, 0, "R13");
    @(negedge clk) cfg_en = 0;
    snoop(A, "R3");
    @(negedge clk) cfg_en = 1;
    access(0, A, 0, 0, "R3");
    access(0, C, 0, 1, "R6");
    access(0, C, 0, 0, "R6");
    @(negedge clk) cfg_en = 1;
    access(0, C, 0, 0, "R6");
    access(2, B, 0, 0, "R7");
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule